// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose I/O pins behind a small memory-mapped register port. Software drives pin values and pin directions, reads back synchronized pin levels, and sets up each pin as an interrupt source. A pin can fire on a rising edge, a falling edge, a high level or a low level. Each detected event sets a sticky status bit. The status bits that software has enabled are combined into one interrupt line for the whole bank.

Each writable register has three addresses: a plain write, a write-one-to-set alias and a write-one-to-clear alias. Software can therefore change single bits without a read-modify-write. Two separate masks control interrupts. A routing mask decides which pins may set their status bit at all. An enable mask decides which status bits reach the interrupt line. Software can flip a pin's polarity bit between events to detect both edges.

Register map: `bus_addr[6:4]` selects the register and `bus_addr[3:2]` selects the access type. Any address with `bus_addr[7]` set is ignored.

| Index | Register |
|---|---|
| 0 | output data |
| 1 | output enable |
| 2 | synchronized input (read only) |
| 3 | routing |
| 4 | interrupt enable |
| 5 | level select |
| 6 | polarity |
| 7 | status |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0. `pin_out`, `pin_oe` and `irq` are 0.
- R2: Each writable register responds to three access types selected by `bus_addr[3:2]`:
  - 0 (offset 0x0) writes the data as given.
  - 1 (offset 0x4) sets the bits written as 1.
  - 2 (offset 0x8) clears the bits written as 1.
  - 3 (offset 0xC) changes nothing.
- R3: `pin_out` equals the output data register (index 0). `pin_oe` equals the output-enable register (index 1), where 1 means the pin is an output.
- R4: Reading index 2 returns `pin_in` after a two-flop synchronizer. A read returns its data on `bus_rdata` one cycle after `bus_rd`, marked by `bus_rvalid`.
- R5: The interrupt type of a pin is the 2-bit code {polarity bit, level bit}. Code 0 (falling edge) sets the status bit when the synchronized pin goes from 1 to 0, and does not set it on a 0-to-1 change.
- R6: Code 2 (rising edge) sets the status bit when the synchronized pin goes from 0 to 1.
- R7: Codes 3 (high level) and 1 (low level) set the status bit in every cycle the pin holds that level, so it sets again at once after a clear.
- R8: A pin whose routing bit is 0 never sets its status bit, whatever its type and level.
- R9: `irq` is the OR of (status AND interrupt enable), registered for one cycle. A status bit is set whatever its enable bit is.
- R10: Status bits are sticky. They stay set after the pin event goes away, until software clears them through the status clear alias.
- R11: If a hardware event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R12: Changing a pin's polarity bit between events changes the edge detected next, so software can detect both edges of the pin.
- R13: Writes to the synchronized-input register (index 2) have no effect; reading it still returns the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 8 | byte address: [6:4] register, [3:2] access type |
| bus_wdata | input | NPINS | write data |
| bus_rdata | output | NPINS | read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | read data valid |
| pin_in | input | NPINS | asynchronous pin levels |
| pin_out | output | NPINS | output data to pads |
| pin_oe | output | NPINS | output enable to pads |
| irq | output | 1 | bank interrupt |

## Verification
The bench uses the default NPINS of 32. This makes the top pin, bit 31, reachable, and the bench exercises it as a rising-edge source and in the alias write patterns. At this width every data word fills the whole bus, so an alias write that touches the wrong bit shows up in the read-back value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } alias_op_e;

  localparam int unsigned RIDX_DOUT  = 0;
  localparam int unsigned RIDX_OE    = 1;
  localparam int unsigned RIDX_DIN   = 2;
  localparam int unsigned RIDX_ROUTE = 3;
  localparam int unsigned RIDX_IEN   = 4;
  localparam int unsigned RIDX_LVL   = 5;
  localparam int unsigned RIDX_POL   = 6;
  localparam int unsigned RIDX_STAT  = 7;
  localparam int unsigned NUM_SLOTS  = 8;
  localparam int unsigned SLOT_BITS  = $clog2(NUM_SLOTS);
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= raw;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] route,
  output logic [W-1:0] evt
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    always_comb begin
      case ({pol[i], lvl[i]})
        2'b00:   hit = prev[i] & ~cur[i];  // falling edge
        2'b01:   hit = ~cur[i];            // low level
        2'b10:   hit = cur[i] & ~prev[i];  // rising edge
        default: hit = cur[i];             // high level
      endcase
    end
    assign evt[i] = hit & route[i];
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sel,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_sel) begin
      case (op)
        OP_WRITE: nxt = wdata;
        OP_SET:   nxt = q | wdata;
        OP_CLEAR: nxt = q & ~wdata;
        default:  nxt = q;
      endcase
    end
    nxt = nxt | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R2
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));

  // R2
  clear_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && op == OP_CLEAR && hw_set == '0) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [SLOT_BITS-1:0] ridx;
  alias_op_e            op;
  logic                 in_range;
  logic [NPINS-1:0]     regq [NUM_SLOTS];
  logic [NPINS-1:0]     s_cur, s_prev, evt;
  logic                 stat_wr;

  assign ridx     = bus_addr[4+SLOT_BITS-1:4];
  assign op       = alias_op_e'(bus_addr[3:2]);
  assign in_range = ~bus_addr[7];
  assign stat_wr  = bus_wr & in_range & (ridx == SLOT_BITS'(RIDX_STAT));

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .cur(s_cur), .prev(s_prev)
  );

  gpio_evt_detect #(.W(NPINS)) u_det (
    .cur(s_cur), .prev(s_prev),
    .lvl(regq[RIDX_LVL]), .pol(regq[RIDX_POL]), .route(regq[RIDX_ROUTE]),
    .evt(evt)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    if (k == RIDX_DIN) begin : g_din
      assign regq[k] = s_cur;
    end else begin : g_reg
      logic [NPINS-1:0] hw;
      logic             sel;
      assign hw  = (k == RIDX_STAT) ? evt : '0;
      assign sel = bus_wr & in_range & (ridx == SLOT_BITS'(k));
      gpio_alias_reg #(.W(NPINS)) u_reg (
        .clk(clk), .rst(rst), .wr_sel(sel), .op(op),
        .wdata(bus_wdata), .hw_set(hw), .q(regq[k])
      );
    end
  end

  assign pin_out = regq[RIDX_DOUT];
  assign pin_oe  = regq[RIDX_OE];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= in_range ? regq[ridx] : '0;
      irq <= |(regq[RIDX_STAT] & regq[RIDX_IEN]);
    end
  end

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(regq[RIDX_STAT]) & $past(regq[RIDX_IEN]))));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(stat_wr) || ((~regq[RIDX_STAT] & $past(regq[RIDX_STAT])) == '0)));

  // R8
  route_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(stat_wr) ||
      ((regq[RIDX_STAT] & ~$past(regq[RIDX_STAT]) & ~$past(regq[RIDX_ROUTE])) == '0)));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt) & ~regq[RIDX_STAT]) == '0));
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int unsigned NP = 32;
  localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h10, A_DIN = 8'h20, A_ROUTE = 8'h30,
                         A_IEN = 8'h40, A_LVL = 8'h50, A_POL = 8'h60, A_STAT = 8'h70;
  localparam logic [7:0] SETO = 8'h04, CLRO = 8'h08, NOPO = 8'h0C;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0, pin_in = '0;
  logic [NP-1:0] bus_rdata, pin_out, pin_oe;
  logic bus_rvalid, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [NP-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data got %h expected none", bus_rdata);
      end else begin
        logic [NP-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s read got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [NP-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [NP-1:0] act, input logic [NP-1:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(pin_out, '0, "R1 pin_out");
    chk(pin_oe, '0, "R1 pin_oe");
    chk(NP'(irq), '0, "R1 irq");
    rd(A_STAT, '0, "R1 status");
    rd(A_ROUTE, '0, "R1 route");
    rd(A_IEN, '0, "R1 enable");

    // R2 / R3 alias writes and output path
    wr(A_DOUT, 32'hA5A5_0F0F);
    rd(A_DOUT, 32'hA5A5_0F0F, "R2 plain write");
    wr(A_DOUT | SETO, 32'h8000_F000);
    rd(A_DOUT, 32'hA5A5_FF0F, "R2 set alias");
    wr(A_DOUT | CLRO, 32'hA500_0001);
    rd(A_DOUT, 32'h00A5_FF0E, "R2 clear alias");
    wr(A_DOUT | NOPO, 32'hFFFF_FFFF);
    rd(A_DOUT, 32'h00A5_FF0E, "R2 unused alias");
    chk(pin_out, 32'h00A5_FF0E, "R3 pin_out");
    wr(A_OE, 32'h8000_0001);
    chk(pin_oe, 32'h8000_0001, "R3 pin_oe");

    // R4 / R13 input sampling, din not writable
    pin_in = 32'h1234_5678;
    idle(3);
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, 32'h1234_5678, "R13 din write ignored");
    rd(A_DIN, 32'h1234_5678, "R4 din");
    pin_in = '0;
    idle(4);

    // R5 falling edge on pin 3 (code 0 = reset defaults)
    wr(A_ROUTE | SETO, 32'h0000_0008);
    wr(A_STAT | CLRO, 32'hFFFF_FFFF);
    pin_in[3] = 1'b1; idle(5);
    rd(A_STAT, '0, "R5 rising ignored");
    pin_in[3] = 1'b0; idle(5);
    rd(A_STAT, 32'h0000_0008, "R5 falling sets");
    chk(NP'(irq), '0, "R9 not enabled");
    pin_in[3] = 1'b1; idle(5);
    rd(A_STAT, 32'h0000_0008, "R10 sticky");
    wr(A_IEN | SETO, 32'h0000_0008);
    idle(2);
    chk(NP'(irq), 1, "R9 irq asserted");
    wr(A_STAT | CLRO, 32'h0000_0008);
    idle(2);
    chk(NP'(irq), '0, "R9 irq after clear");
    rd(A_STAT, '0, "R10 clear alias");

    // R6 rising edge on pin 31
    wr(A_POL | SETO, 32'h8000_0000);
    wr(A_ROUTE | SETO, 32'h8000_0000);
    pin_in[31] = 1'b1; idle(5);
    rd(A_STAT, 32'h8000_0000, "R6 rising sets");
    wr(A_STAT | CLRO, 32'h8000_0000);
    pin_in[31] = 1'b0; idle(5);
    rd(A_STAT, '0, "R6 falling ignored");

    // R12 polarity toggle on pin 3 (pin currently high)
    wr(A_POL | SETO, 32'h0000_0008);
    pin_in[3] = 1'b0; idle(5);
    rd(A_STAT, '0, "R12 fall ignored when rising");
    pin_in[3] = 1'b1; idle(5);
    rd(A_STAT, 32'h0000_0008, "R12 rise detected");
    wr(A_STAT | CLRO, 32'h0000_0008);
    wr(A_POL | CLRO, 32'h0000_0008);
    pin_in[3] = 1'b0; idle(5);
    rd(A_STAT, 32'h0000_0008, "R12 fall after toggle");
    wr(A_STAT | CLRO, 32'h0000_0008);

    // R7 / R11 high level on pin 5
    wr(A_LVL | SETO, 32'h0000_0020);
    wr(A_POL | SETO, 32'h0000_0020);
    wr(A_ROUTE | SETO, 32'h0000_0020);
    pin_in[5] = 1'b1; idle(5);
    wr(A_STAT | CLRO, 32'h0000_0020);
    rd(A_STAT, 32'h0000_0020, "R11 level set beats clear");
    pin_in[5] = 1'b0; idle(5);
    wr(A_STAT | CLRO, 32'h0000_0020);
    rd(A_STAT, '0, "R7 high level released");

    // R8 unrouted high-level pin 10
    wr(A_LVL | SETO, 32'h0000_0400);
    wr(A_POL | SETO, 32'h0000_0400);
    pin_in[10] = 1'b1; idle(5);
    rd(A_STAT, '0, "R8 unrouted pin");

    // R7 low level on pin 6 (pin low)
    wr(A_LVL | SETO, 32'h0000_0040);
    wr(A_ROUTE | SETO, 32'h0000_0040);
    idle(3);
    rd(A_STAT, 32'h0000_0040, "R7 low level sets");
    pin_in[6] = 1'b1; idle(5);
    wr(A_STAT | CLRO, 32'h0000_0040);
    rd(A_STAT, '0, "R7 low level released");

    idle(4);
    chk(NP'(exp_q.size()), '0, "R4 all reads returned");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule